// File: doc/BRIEF.md
# Dual Gated Counter/Timer

This block holds two counter/timer channels that a processor sets up through a small byte-wide register port. Each channel counts either an internal tick or falling edges on its own external count pin. It can be held off by its run bit, or, when hardware gating is selected, by an external gate line whose active level is programmable. One mode register sets the channel layout and the count source for both channels. Each channel can be a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads itself. In the fourth layout, channel 0 becomes two independent 8-bit counters and channel 1 is frozen.

Overflows set sticky flags. The flags are brought out as ports and are cleared only by software through the control register. Software reaches the count bytes, the control register and the mode register through one write strobe, an address, write data and combinational read data. A write always takes priority over counting that happens in the same cycle.

Top module: `dual_cnt_timer`

## Requirements
- R1: After reset, every readable register (control 0x88, mode 0x89, count bytes 0x8A to 0x8D) reads 0x00, and `ovf_flag` is 0.
- R2: Register map: the mode register at 0x89 reads back what was last written to it. Its bit fields are [7] gate enable ch1, [6] external source ch1, [5:4] mode ch1, [3] gate enable ch0, [2] external source ch0, [1:0] mode ch0. The control register is 0x88: bit0 run ch0, bit1 run ch1, bit2 flag ch0, bit3 flag ch1. The counts are 0x8A low ch0, 0x8B low ch1, 0x8C high ch0 and 0x8D high ch1. Any other address reads 0x00.
- R3: A channel counts only while its run bit is 1 and, if its gate-enable bit is 1, its `gate_in` equals its `gate_pol` (1 means active-high, 0 means active-low).
- R4: With external source 0, a channel steps every cycle when its `clk_sel` bit is 1 and only on cycles where `tick_pre` is 1 when that bit is 0. With external source 1, a channel steps once for each falling edge of its `ext_pin`. The count changes at the third rising clock edge after the pin falls.
- R5: Mode 00 is 13-bit: low byte bits [4:0] carry into the 8-bit high byte, and low byte bits [7:5] are left untouched. The flag is set when all 13 bits roll over to zero.
- R6: Mode 01 is 16-bit, with the high byte above the low byte. The flag is set when the count rolls from 0xFFFF to 0x0000.
- R7: Mode 10 counts in the low byte. When the low byte steps past 0xFF, it is loaded from the high byte and the flag is set in the same cycle.
- R8: Mode 11 on channel 0 splits it into two counters. The low byte uses channel 0's controls and sets flag 0. The high byte counts internal ticks, selected by `clk_sel[0]`, whenever run ch1 is 1, and it sets flag 1. While the split is active, flag 1 is set only by channel 0's high byte.
- R9: Mode 11 on channel 1 stops channel 1: its count bytes change only by register writes.
- R10: Flags are sticky and are driven on `ovf_flag`. A write to the control register loads run and flag bits from write data and wins over an overflow in the same cycle.
- R11: A write to a count byte loads that byte and cancels the channel's step in that cycle. In mode 11 on channel 0, only the written half skips its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_pre | input | 1 | Prescaled tick, one-cycle pulses |
| clk_sel | input | 2 | Per-channel internal source select: 1 = every cycle, 0 = `tick_pre` |
| gate_pol | input | 2 | Per-channel active level of `gate_in` |
| gate_in | input | 2 | Per-channel gate lines, synchronous to `clk` |
| ext_pin | input | 2 | Per-channel external count pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| ovf_flag | output | 2 | Sticky overflow flags, ch1 in bit 1 |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-bit prescale field in 13-bit mode, and a two-stage pin synchronizer. With these values every rollover lies within a few cycles of a preloaded 0xFF or 0x1F. Directed cases cover each mode's rollover, reload with a write that collides with it, gate polarity, and the exact latency from a pin edge to the count change. A seeded random phase then mixes mode changes, count preloads, run and flag writes, gate and pin activity, and compares every readable register and both flags against a bench model cycle by cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    MODE_13    = 2'b00,
    MODE_16    = 2'b01,
    MODE_RLD   = 2'b10,
    MODE_SPLIT = 2'b11
  } dct_mode_e;

  // Per-channel nibble of the mode register
  typedef struct packed {
    logic      gate;
    logic      ext;
    dct_mode_e mode;
  } dct_chcfg_t;

endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              prev_q, prev_d;

  always_comb begin
    sr_d   = {sr_q[STAGES-2:0], pin};
    prev_d = sr_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sr_q[STAGES-1];

endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dct_mode_e     mode,
  input  logic          inc,
  input  logic          hi_inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic          ovf_main,
  output logic          ovf_hi
);
  localparam logic [DW-1:0]    ONE  = 1;
  localparam logic [PRE_W-1:0] PONE = 1;

  logic [DW-1:0] lo_d, hi_d;
  logic          any_wr;

  always_comb begin
    lo_d     = lo;
    hi_d     = hi;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    any_wr   = wr_lo | wr_hi;
    case (mode)
      MODE_13: if (inc && !any_wr) begin
        lo_d[PRE_W-1:0] = lo[PRE_W-1:0] + PONE;
        if (&lo[PRE_W-1:0]) begin
          hi_d     = hi + ONE;
          ovf_main = &hi;
        end
      end
      MODE_16: if (inc && !any_wr) begin
        lo_d = lo + ONE;
        if (&lo) begin
          hi_d     = hi + ONE;
          ovf_main = &hi;
        end
      end
      MODE_RLD: if (inc && !any_wr) begin
        if (&lo) begin
          lo_d     = hi;
          ovf_main = 1'b1;
        end else begin
          lo_d = lo + ONE;
        end
      end
      default: if (SPLIT_OK) begin
        if (inc && !wr_lo) begin
          lo_d     = lo + ONE;
          ovf_main = &lo;
        end
        if (hi_inc && !wr_hi) begin
          hi_d   = hi + ONE;
          ovf_hi = &hi;
        end
      end
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!SPLIT_OK && mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

  // R11
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo == $past(wdata)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RLD && inc && (&lo) && !wr_lo && !wr_hi) |=> (lo == $past(hi)));

endmodule

// File: rtl/dual_cnt_timer.sv
module dual_cnt_timer
  import dct_pkg::*;
#(
  parameter int              AW          = 8,
  parameter int              PRE_W       = 5,
  parameter int              SYNC_STAGES = 2,
  parameter logic [AW-1:0]   CTRL_ADDR   = 8'h88,
  parameter logic [AW-1:0]   MODE_ADDR   = 8'h89,
  parameter logic [AW-1:0]   CNT_BASE    = 8'h8A
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick_pre,
  input  logic [1:0]    clk_sel,
  input  logic [1:0]    gate_pol,
  input  logic [1:0]    gate_in,
  input  logic [1:0]    ext_pin,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [1:0]    ovf_flag
);
  localparam int            DW   = 8;
  localparam int            NCH  = 2;
  localparam logic [AW-1:0] LO1A = CNT_BASE + AW'(1);
  localparam logic [AW-1:0] HI0A = CNT_BASE + AW'(2);
  localparam logic [AW-1:0] HI1A = CNT_BASE + AW'(3);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic [DW-1:0]  mode_q, mode_d;
  logic [NCH-1:0] run_q, run_d, flag_q, flag_d;
  dct_chcfg_t     cfg [NCH];
  logic [NCH-1:0] wr_lo, wr_hi, fall, en, inc, hi_inc, ovm, ovh;
  logic [DW-1:0]  cnt_lo [NCH];
  logic [DW-1:0]  cnt_hi [NCH];
  logic           wr_ctrl, wr_mode, split0;

  always_comb begin
    wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);
    wr_mode = bus_we && (bus_addr == MODE_ADDR);
    for (int i = 0; i < NCH; i++) begin
      cfg[i]   = dct_chcfg_t'(mode_q[4*i +: 4]);
      wr_lo[i] = bus_we && (bus_addr == CNT_BASE + AW'(i));
      wr_hi[i] = bus_we && (bus_addr == CNT_BASE + AW'(i + NCH));
    end
    split0 = (cfg[0].mode == MODE_SPLIT);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin[g]), .fall(fall[g])
    );

    assign en[g]  = run_q[g] & (~cfg[g].gate | (gate_in[g] ~^ gate_pol[g]));
    assign inc[g] = en[g] & (cfg[g].ext ? fall[g] : (clk_sel[g] | tick_pre));

    if (g == 0) begin : g_hi
      assign hi_inc[g] = run_q[1] & (clk_sel[0] | tick_pre);
    end else begin : g_nohi
      assign hi_inc[g] = 1'b0;
    end

    dct_channel #(.DW(DW), .PRE_W(PRE_W), .SPLIT_OK(g == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .mode(cfg[g].mode), .inc(inc[g]),
      .hi_inc(hi_inc[g]), .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
      .wdata(bus_wdata), .lo(cnt_lo[g]), .hi(cnt_hi[g]),
      .ovf_main(ovm[g]), .ovf_hi(ovh[g])
    );
  end

  always_comb begin
    mode_d    = mode_q;
    run_d     = run_q;
    flag_d[0] = flag_q[0] | ovm[0];
    flag_d[1] = flag_q[1] | (split0 ? ovh[0] : (ovm[1] | ovh[1]));
    if (wr_ctrl) begin
      run_d  = bus_wdata[1:0];
      flag_d = bus_wdata[3:2];
    end
    if (wr_mode) mode_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (bus_addr)
      CTRL_ADDR: bus_rdata = {4'b0000, flag_q, run_q};
      MODE_ADDR: bus_rdata = mode_q;
      CNT_BASE:  bus_rdata = cnt_lo[0];
      LO1A:      bus_rdata = cnt_lo[1];
      HI0A:      bus_rdata = cnt_hi[0];
      HI1A:      bus_rdata = cnt_hi[1];
      default:   bus_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !wr_lo[0] && !wr_hi[0] && !split0) |=> ($stable(cnt_lo[0]) && $stable(cnt_hi[0])));

  // R1
  rst_flag_chk: assert property (@(posedge clk)
    !rst_n |-> (ovf_flag == 2'b00));

endmodule

// File: tb/tb_dual_cnt_timer.sv
module tb_dual_cnt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_pre = 1'b0;
  logic [1:0] clk_sel = 2'b11, gate_pol = 2'b00, gate_in = 2'b00, ext_pin = 2'b00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] ovf_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_mode = '0;
  logic [1:0] m_run = '0, m_flag = '0;
  logic [7:0] m_lo [2] = '{8'h00, 8'h00};
  logic [7:0] m_hi [2] = '{8'h00, 8'h00};
  logic [1:0] p_s1 = '0, p_s2 = '0, p_pv = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cnt_timer dut (
    .clk(clk), .rst_ni(rst_ni), .tick_pre(tick_pre), .clk_sel(clk_sel),
    .gate_pol(gate_pol), .gate_in(gate_in), .ext_pin(ext_pin),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h88:   return {4'b0000, m_flag, m_run};
      8'h89:   return m_mode;
      8'h8A:   return m_lo[0];
      8'h8B:   return m_lo[1];
      8'h8C:   return m_hi[0];
      8'h8D:   return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    logic [1:0] fl, ovm, ovh;
    logic [7:0] nlo [2];
    logic [7:0] nhi [2];
    logic [1:0] md;
    logic ena, src, inc, wl, wh, hinc;
    fl = p_pv & ~p_s2;
    p_pv = p_s2; p_s2 = p_s1; p_s1 = ext_pin;
    ovm = '0; ovh = '0;
    for (int c = 0; c < 2; c++) begin
      md   = m_mode[4*c +: 2];
      ena  = m_run[c] & (!m_mode[4*c+3] | (gate_in[c] == gate_pol[c]));
      src  = m_mode[4*c+2] ? fl[c] : (clk_sel[c] | tick_pre);
      inc  = ena & src;
      wl   = bus_we && bus_addr == 8'h8A + 8'(c);
      wh   = bus_we && bus_addr == 8'h8C + 8'(c);
      hinc = (c == 0) && m_run[1] && (clk_sel[0] || tick_pre);
      nlo[c] = m_lo[c]; nhi[c] = m_hi[c];
      if (md == 2'b00 && inc && !wl && !wh) begin
        nlo[c] = {m_lo[c][7:5], 5'(m_lo[c][4:0] + 5'd1)};
        if (m_lo[c][4:0] == 5'h1F) begin nhi[c] = m_hi[c] + 8'd1; ovm[c] = (m_hi[c] == 8'hFF); end
      end else if (md == 2'b01 && inc && !wl && !wh) begin
        nlo[c] = m_lo[c] + 8'd1;
        if (m_lo[c] == 8'hFF) begin nhi[c] = m_hi[c] + 8'd1; ovm[c] = (m_hi[c] == 8'hFF); end
      end else if (md == 2'b10 && inc && !wl && !wh) begin
        ovm[c] = (m_lo[c] == 8'hFF);
        nlo[c] = ovm[c] ? m_hi[c] : m_lo[c] + 8'd1;
      end else if (md == 2'b11 && c == 0) begin
        if (inc && !wl)  begin nlo[c] = m_lo[c] + 8'd1; ovm[c] = (m_lo[c] == 8'hFF); end
        if (hinc && !wh) begin nhi[c] = m_hi[c] + 8'd1; ovh[c] = (m_hi[c] == 8'hFF); end
      end
      if (wl) nlo[c] = bus_wdata;
      if (wh) nhi[c] = bus_wdata;
    end
    m_flag[0] = m_flag[0] | ovm[0];
    m_flag[1] = m_flag[1] | ((m_mode[1:0] == 2'b11) ? ovh[0] : ovm[1]);
    if (bus_we && bus_addr == 8'h88) begin m_run = bus_wdata[1:0]; m_flag = bus_wdata[3:2]; end
    if (bus_we && bus_addr == 8'h89) m_mode = bus_wdata;
    for (int c = 0; c < 2; c++) begin m_lo[c] = nlo[c]; m_hi[c] = nhi[c]; end
  endtask

  // one clock: inputs already set at a negedge; returns at the next negedge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 8'h00);
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_flag(input logic [1:0] exp, input string tag);
    checks++;
    if (ovf_flag !== exp) begin
      fails++;
      $display("FAIL %s ovf_flag: actual %b expected %b", tag, ovf_flag, exp);
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 8'h88; a <= 8'h8D; a++) chk_reg(8'(a), 8'h00, "R1");
    chk_flag(2'b00, "R1");

    // R2 mode register readback and unmapped address
    cyc(1'b1, 8'h89, 8'hA5); chk_reg(8'h89, 8'hA5, "R2");
    cyc(1'b1, 8'h89, 8'h00); chk_reg(8'h80, 8'h00, "R2");

    // R6 16-bit rollover
    cyc(1'b1, 8'h89, 8'h01); cyc(1'b1, 8'h8A, 8'hFE); cyc(1'b1, 8'h8C, 8'hFF);
    cyc(1'b1, 8'h88, 8'h01);
    idle(1); chk_reg(8'h8A, 8'hFF, "R6");
    idle(1); chk_reg(8'h8A, 8'h00, "R6"); chk_reg(8'h8C, 8'h00, "R6");
    chk_flag(2'b01, "R6");
    idle(2); chk_flag(2'b01, "R10");

    // R10 clear by write; R7 reload with a colliding control write
    cyc(1'b1, 8'h88, 8'h00); chk_flag(2'b00, "R10");
    cyc(1'b1, 8'h89, 8'h02); cyc(1'b1, 8'h8C, 8'h80); cyc(1'b1, 8'h8A, 8'hFF);
    cyc(1'b1, 8'h88, 8'h01);
    cyc(1'b1, 8'h88, 8'h01);
    chk_reg(8'h8A, 8'h80, "R7"); chk_flag(2'b00, "R10");
    idle(1); chk_reg(8'h8A, 8'h81, "R7");

    // R5 13-bit rollover, upper low-byte bits untouched
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h00); cyc(1'b1, 8'h8C, 8'hFF); cyc(1'b1, 8'h8A, 8'hFE);
    cyc(1'b1, 8'h88, 8'h01);
    idle(1); chk_reg(8'h8A, 8'hFF, "R5");
    idle(1); chk_reg(8'h8A, 8'hE0, "R5"); chk_reg(8'h8C, 8'h00, "R5");
    chk_flag(2'b01, "R5");

    // R3 gating with polarity
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h08); gate_pol[0] = 1'b1; gate_in[0] = 1'b0;
    cyc(1'b1, 8'h8A, 8'h00); cyc(1'b1, 8'h8C, 8'h00);
    cyc(1'b1, 8'h88, 8'h01);
    idle(3); chk_reg(8'h8A, 8'h00, "R3");
    gate_in[0] = 1'b1; idle(2); chk_reg(8'h8A, 8'h02, "R3");
    gate_pol[0] = 1'b0; idle(2); chk_reg(8'h8A, 8'h02, "R3");
    gate_in[0] = 1'b0; idle(1); chk_reg(8'h8A, 8'h03, "R3");

    // R4 prescaled tick select
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h00); clk_sel[0] = 1'b0;
    cyc(1'b1, 8'h8A, 8'h00); cyc(1'b1, 8'h88, 8'h01);
    idle(3); chk_reg(8'h8A, 8'h00, "R4");
    tick_pre = 1'b1; idle(1); tick_pre = 1'b0; chk_reg(8'h8A, 8'h01, "R4");

    // R4 external falling edge and its latency
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h04); cyc(1'b1, 8'h8A, 8'h00);
    ext_pin[0] = 1'b1; idle(4);
    cyc(1'b1, 8'h88, 8'h01); chk_reg(8'h8A, 8'h00, "R4");
    ext_pin[0] = 1'b0; idle(2); chk_reg(8'h8A, 8'h00, "R4");
    idle(1); chk_reg(8'h8A, 8'h01, "R4");
    idle(3); chk_reg(8'h8A, 8'h01, "R4");

    // R8 split mode
    clk_sel = 2'b11;
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h03);
    cyc(1'b1, 8'h8A, 8'hFE); cyc(1'b1, 8'h8C, 8'hFF);
    cyc(1'b1, 8'h8B, 8'h00); cyc(1'b1, 8'h8D, 8'h00);
    cyc(1'b1, 8'h88, 8'h02);
    idle(1);
    chk_reg(8'h8C, 8'h00, "R8"); chk_reg(8'h8A, 8'hFE, "R8");
    chk_reg(8'h8B, 8'h01, "R8"); chk_flag(2'b10, "R8");
    cyc(1'b1, 8'h88, 8'h01);
    idle(2); chk_reg(8'h8A, 8'h00, "R8"); chk_reg(8'h8C, 8'h01, "R8");
    chk_flag(2'b01, "R8");

    // R9 channel 1 frozen in mode 11
    cyc(1'b1, 8'h88, 8'h00);
    cyc(1'b1, 8'h89, 8'h30); cyc(1'b1, 8'h8B, 8'h10);
    cyc(1'b1, 8'h88, 8'h02);
    idle(3); chk_reg(8'h8B, 8'h10, "R9");

    // R11 write beats increment
    cyc(1'b1, 8'h89, 8'h01); cyc(1'b1, 8'h88, 8'h01);
    cyc(1'b1, 8'h8A, 8'h40); chk_reg(8'h8A, 8'h40, "R11");
    idle(1); chk_reg(8'h8A, 8'h41, "R11");
    cyc(1'b1, 8'h88, 8'h00);

    // random phase against the bench model (R2..R11)
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d;
      a = 8'h88 + 8'($urandom_range(0, 6));
      d = ($urandom_range(0, 1) == 1) ? (8'hF0 | 8'($urandom_range(0, 15))) : 8'($urandom);
      if (a == 8'h88) d = d & 8'h0F;
      tick_pre = ($urandom_range(0, 3) == 0);
      clk_sel  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
      gate_in  = 2'($urandom);
      if ($urandom_range(0, 15) == 0) gate_pol = 2'($urandom);
      if ($urandom_range(0, 2) == 0) ext_pin = 2'($urandom);
      cyc(($urandom_range(0, 9) == 0), a, d);
      a = 8'h88 + 8'($urandom_range(0, 6));
      chk_reg(a, m_read(a), "R2_R5_R6_R7_R8_R11");
      chk_flag(m_flag, "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule